// File: doc/BRIEF.md
# Handshake Field Read Crossing

This block carries the value of one register field, which lives in the register-block clock domain, across to a read-data bus clocked by an unrelated hardware clock. The register side owns the field: software-side logic writes it through a write strobe and sees its current value. When a read request is accepted, the register side raises a busy flag and flips a request toggle. The toggle is synchronized into the hardware clock domain, and a change in the synchronized level becomes a single-cycle load pulse.

On that pulse the hardware side copies the field into its read-data register and raises a one-cycle valid strobe. It then flips an acknowledge toggle, which travels back through its own synchronizer. A detected change on the synchronized acknowledge ends the busy period. Field writes are refused while busy is high, so the multi-bit field value is steady for the whole time the hardware side may sample it. Requests that arrive while busy is high are dropped.

Top module: `cdc_field_rd_hs`

## Requirements
- R1: After reset in both domains, `rd_busy` is 0, `fld_q` equals the parameter `FIELD_INIT` (default 0), `hw_rd_data` is 0 and `hw_rd_vld` is 0.
- R2: When `rd_busy` is 0, a cycle with `fld_we` high loads `fld_wd` into `fld_q` at that register-clock edge.
- R3: When `rd_busy` is 1, `fld_we` has no effect and `fld_q` keeps its value.
- R4: A cycle with `rd_req` high while `rd_busy` is 0 sets `rd_busy` at that register-clock edge.
- R5: A cycle with `rd_req` high while `rd_busy` is 1 is dropped: it causes no extra transfer and no extra busy period.
- R6: Each accepted request produces exactly one `hw_rd_vld` pulse, one hardware-clock cycle wide, with `hw_rd_data` equal to the `fld_q` value in force while `rd_busy` was high.
- R7: `hw_rd_data` changes only in a cycle where `hw_rd_vld` is high, and otherwise holds its last loaded value.
- R8: `rd_busy` returns to 0 only after the acknowledge of the transfer has crossed back into the register domain, and does so without further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-block domain clock |
| rst_reg_n | input | 1 | Asynchronous active-low reset, register domain |
| rd_req | input | 1 | Read request, one register-clock cycle per request |
| fld_we | input | 1 | Field write strobe |
| fld_wd | input | DATA_W | Field write data |
| fld_q | output | DATA_W | Current field value |
| rd_busy | output | 1 | Transfer in progress; field writes and new requests refused |
| clk_hw | input | 1 | Hardware domain clock |
| rst_hw_n | input | 1 | Asynchronous active-low reset, hardware domain |
| hw_rd_data | output | DATA_W | Field value presented to the hardware side |
| hw_rd_vld | output | 1 | One-cycle strobe marking a newly loaded `hw_rd_data` |

## Verification
The assertions watch, every cycle and in each clock domain separately, the local rules: busy rising on an accepted request, the field frozen while busy and loaded when idle, the valid strobe never lasting two cycles, the read data moving only under the strobe, and busy falling only on a returned acknowledge. What spans both domains can only be shown by the scenarios: that the value landing on the hardware bus is the field value frozen by the request, that a write attempted mid-transfer does not reach it, that a request issued while busy yields no second transfer, and that every busy period ends.

// File: rtl/cdc_rd_pkg.sv
package cdc_rd_pkg;

  typedef enum logic {
    RD_IDLE = 1'b0,
    RD_WAIT = 1'b1
  } rd_state_e;

  // A toggle-encoded event is seen when two successive samples differ.
  function automatic logic toggle_event(input logic newer, input logic older);
    return newer ^ older;
  endfunction

  // Next value of a toggle line: flip on an event, hold otherwise.
  function automatic logic toggle_next(input logic cur, input logic fire);
    return fire ? ~cur : cur;
  endfunction

endpackage

// File: rtl/cdc_rd_sync.sv
// Level synchronizer with one history flop after the last stage, so the
// caller can detect a change between the two final samples.
module cdc_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q,
  output logic q_prev
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q      = chain_q[CHAIN-2];
  assign q_prev = chain_q[CHAIN-1];
endmodule

// File: rtl/cdc_rd_reg_side.sv
module cdc_rd_reg_side
  import cdc_rd_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [DATA_W-1:0] FIELD_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              fld_we,
  input  logic [DATA_W-1:0] fld_wd,
  input  logic              ack_evt,
  output logic [DATA_W-1:0] fld_q,
  output logic              rd_busy,
  output logic              req_tgl,
  output logic              req_accept
);
  rd_state_e state_q, state_d;
  logic      fld_load;

  assign req_accept = (state_q == RD_IDLE) && rd_req;
  assign fld_load   = (state_q == RD_IDLE) && fld_we;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RD_IDLE: if (rd_req)  state_d = RD_WAIT;
      RD_WAIT: if (ack_evt) state_d = RD_IDLE;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      req_tgl <= 1'b0;
      fld_q   <= FIELD_INIT;
    end else begin
      state_q <= state_d;
      req_tgl <= toggle_next(req_tgl, req_accept);
      if (fld_load) fld_q <= fld_wd;
    end
  end

  assign rd_busy = (state_q == RD_WAIT);
endmodule

// File: rtl/cdc_rd_hw_side.sv
module cdc_rd_hw_side
  import cdc_rd_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl_async,
  input  logic [DATA_W-1:0] fld_async,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              ack_tgl,
  output logic              load_evt
);
  logic req_s, req_s_prev;

  cdc_rd_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (req_tgl_async),
    .q       (req_s),
    .q_prev  (req_s_prev)
  );

  assign load_evt = toggle_event(req_s, req_s_prev);

  // The field is frozen on the register side for the whole transfer, so the
  // multi-bit capture here sees a settled value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
      ack_tgl <= 1'b0;
    end else begin
      rd_vld  <= load_evt;
      ack_tgl <= toggle_next(ack_tgl, load_evt);
      if (load_evt) rd_data <= fld_async;
    end
  end
endmodule

// File: rtl/cdc_field_rd_hs.sv
module cdc_field_rd_hs
  import cdc_rd_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] FIELD_INIT  = '0
) (
  input  logic              clk_reg,
  input  logic              rst_reg_n,
  input  logic              rd_req,
  input  logic              fld_we,
  input  logic [DATA_W-1:0] fld_wd,
  output logic [DATA_W-1:0] fld_q,
  output logic              rd_busy,
  input  logic              clk_hw,
  input  logic              rst_hw_n,
  output logic [DATA_W-1:0] hw_rd_data,
  output logic              hw_rd_vld
);
  logic req_tgl;
  logic req_accept;
  logic ack_tgl;
  logic load_evt;
  logic ack_s, ack_s_prev;
  logic ack_evt;

  cdc_rd_reg_side #(.DATA_W(DATA_W), .FIELD_INIT(FIELD_INIT)) u_reg (
    .clk        (clk_reg),
    .rst_n      (rst_reg_n),
    .rd_req     (rd_req),
    .fld_we     (fld_we),
    .fld_wd     (fld_wd),
    .ack_evt    (ack_evt),
    .fld_q      (fld_q),
    .rd_busy    (rd_busy),
    .req_tgl    (req_tgl),
    .req_accept (req_accept)
  );

  cdc_rd_hw_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_hw (
    .clk           (clk_hw),
    .rst_n         (rst_hw_n),
    .req_tgl_async (req_tgl),
    .fld_async     (fld_q),
    .rd_data       (hw_rd_data),
    .rd_vld        (hw_rd_vld),
    .ack_tgl       (ack_tgl),
    .load_evt      (load_evt)
  );

  cdc_rd_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk     (clk_reg),
    .rst_n   (rst_reg_n),
    .d_async (ack_tgl),
    .q       (ack_s),
    .q_prev  (ack_s_prev)
  );

  assign ack_evt = toggle_event(ack_s, ack_s_prev);
endmodule

// File: rtl/cdc_field_rd_hs_chk.sv
module cdc_field_rd_hs_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_reg,
  input logic              rst_reg_n,
  input logic              rd_req,
  input logic              fld_we,
  input logic [DATA_W-1:0] fld_wd,
  input logic [DATA_W-1:0] fld_q,
  input logic              rd_busy,
  input logic              ack_evt,
  input logic              clk_hw,
  input logic              rst_hw_n,
  input logic [DATA_W-1:0] hw_rd_data,
  input logic              hw_rd_vld
);
  assert_busy_set_R4: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
    (!rd_busy && rd_req) |=> rd_busy);

  assert_field_load_R2: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
    (!rd_busy && fld_we) |=> (fld_q == $past(fld_wd)));

  assert_field_frozen_R3: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
    rd_busy |=> $stable(fld_q));

  assert_busy_end_on_ack_R8: assert property (@(posedge clk_reg) disable iff (!rst_reg_n)
    (rd_busy && !ack_evt) |=> rd_busy);

  assert_vld_one_cycle_R6: assert property (@(posedge clk_hw) disable iff (!rst_hw_n)
    hw_rd_vld |=> !hw_rd_vld);

  assert_data_hold_R7: assert property (@(posedge clk_hw) disable iff (!rst_hw_n)
    !hw_rd_vld |-> $stable(hw_rd_data));
endmodule

bind cdc_field_rd_hs cdc_field_rd_hs_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_reg    (clk_reg),
  .rst_reg_n  (rst_reg_n),
  .rd_req     (rd_req),
  .fld_we     (fld_we),
  .fld_wd     (fld_wd),
  .fld_q      (fld_q),
  .rd_busy    (rd_busy),
  .ack_evt    (ack_evt),
  .clk_hw     (clk_hw),
  .rst_hw_n   (rst_hw_n),
  .hw_rd_data (hw_rd_data),
  .hw_rd_vld  (hw_rd_vld)
);

// File: tb/cdc_field_rd_hs_tb.sv
`timescale 1ns/1ps
module cdc_field_rd_hs_tb_top;
  localparam int DATA_W   = 32;
  localparam int BUSY_MAX = 80;

  logic              clk_reg = 1'b0;
  logic              clk_hw  = 1'b0;
  logic              rst_reg_n = 1'b0;
  logic              rst_hw_n  = 1'b0;
  logic              rd_req = 1'b0;
  logic              fld_we = 1'b0;
  logic [DATA_W-1:0] fld_wd = '0;
  logic [DATA_W-1:0] fld_q;
  logic              rd_busy;
  logic [DATA_W-1:0] hw_rd_data;
  logic              hw_rd_vld;

  int n_cmp = 0;
  int n_bad = 0;
  int vld_cnt = 0;
  bit finished = 1'b0;

  always #4 clk_reg = ~clk_reg;     // 125 MHz
  always #6.5 clk_hw = ~clk_hw;     // unrelated hardware clock

  cdc_field_rd_hs #(.DATA_W(DATA_W)) dut_i (
    .clk_reg    (clk_reg),
    .rst_reg_n  (rst_reg_n),
    .rd_req     (rd_req),
    .fld_we     (fld_we),
    .fld_wd     (fld_wd),
    .fld_q      (fld_q),
    .rd_busy    (rd_busy),
    .clk_hw     (clk_hw),
    .rst_hw_n   (rst_hw_n),
    .hw_rd_data (hw_rd_data),
    .hw_rd_vld  (hw_rd_vld)
  );

  // Count strobe cycles away from the hardware clock's active edge.
  always @(negedge clk_hw) if (hw_rd_vld) vld_cnt++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_reg);
  endtask

  task automatic apply_reset();
    rst_reg_n = 1'b0;
    rst_hw_n  = 1'b0;
    rd_req = 1'b0;
    fld_we = 1'b0;
    reg_cycles(4);
    rst_reg_n = 1'b1;
    rst_hw_n  = 1'b1;
    reg_cycles(2);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (rd_busy && n < BUSY_MAX) begin
      @(negedge clk_reg);
      n++;
    end
    check(req, {63'd0, rd_busy}, 64'd0);
  endtask

  task automatic t_reset_state();
    apply_reset();
    check("R1 busy",   {63'd0, rd_busy}, 64'd0);
    check("R1 fld_q",  64'(fld_q), 64'd0);
    check("R1 rd_data",64'(hw_rd_data), 64'd0);
    check("R1 rd_vld", {63'd0, hw_rd_vld}, 64'd0);
  endtask

  task automatic t_write(input logic [DATA_W-1:0] v);
    fld_we = 1'b1;
    fld_wd = v;
    @(negedge clk_reg);
    fld_we = 1'b0;
    check("R2 idle write", 64'(fld_q), 64'(v));
  endtask

  task automatic t_read(input logic [DATA_W-1:0] exp);
    int c0 = vld_cnt;
    rd_req = 1'b1;
    @(negedge clk_reg);
    rd_req = 1'b0;
    check("R4 busy set", {63'd0, rd_busy}, 64'd1);
    wait_idle("R8 busy cleared");
    reg_cycles(2);
    check("R6 one strobe", 64'(vld_cnt - c0), 64'd1);
    check("R6 data", 64'(hw_rd_data), 64'(exp));
  endtask

  task automatic t_write_while_busy(input logic [DATA_W-1:0] other);
    logic [DATA_W-1:0] held = fld_q;
    rd_req = 1'b1;
    @(negedge clk_reg);
    rd_req = 1'b0;
    fld_we = 1'b1;
    fld_wd = other;
    @(negedge clk_reg);
    fld_we = 1'b0;
    check("R3 write ignored", 64'(fld_q), 64'(held));
    wait_idle("R8 busy cleared");
    reg_cycles(2);
    check("R3 data unchanged", 64'(hw_rd_data), 64'(held));
    check("R3 field after", 64'(fld_q), 64'(held));
  endtask

  task automatic t_req_while_busy();
    int c0 = vld_cnt;
    rd_req = 1'b1;
    @(negedge clk_reg);
    rd_req = 1'b1;          // second request, busy already high
    @(negedge clk_reg);
    rd_req = 1'b0;
    wait_idle("R8 busy cleared");
    reg_cycles(30);
    check("R5 single transfer", 64'(vld_cnt - c0), 64'd1);
    check("R5 no extra busy", {63'd0, rd_busy}, 64'd0);
  endtask

  task automatic t_hold(input logic [DATA_W-1:0] exp);
    int c0 = vld_cnt;
    t_write(~exp);
    reg_cycles(20);
    check("R7 data held", 64'(hw_rd_data), 64'(exp));
    check("R7 no strobe", 64'(vld_cnt - c0), 64'd0);
  endtask

  initial begin
    t_reset_state();
    t_write(32'hA5A5_3C3C);
    t_read(32'hA5A5_3C3C);
    t_hold(32'hA5A5_3C3C);
    t_write(32'hFFFF_FFFF);
    t_read(32'hFFFF_FFFF);
    t_write(32'h0000_0000);
    t_read(32'h0000_0000);
    t_write(32'h1234_5678);
    t_write_while_busy(32'hDEAD_BEEF);
    t_write(32'h0F0F_00FF);
    t_req_while_busy();
    check("R5 data", 64'(hw_rd_data), 64'h0F0F_00FF);
    // Back-to-back requests right after completion.
    t_write(32'h8000_0001);
    t_read(32'h8000_0001);
    t_read(32'h8000_0001);
    t_reset_state();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule